// File: doc/BRIEF.md
# Static Memory Byte-Lane Strobe Generator

This block drives the control pins of one asynchronous static memory bank that is 8, 16 or 32 bits wide. It takes a single access request: read or write, a byte address, and a transfer size of byte, halfword or word. It then runs a fixed three-phase cycle of address setup, strobe and hold. During that cycle it produces a chip select, an output enable, a write enable, four active-low byte-lane strobes and a 21-bit word address for the devices.

A per-bank lane policy input changes what the lane strobes mean.
- With the policy clear, each lane strobe is the write enable of one 8-bit device. The strobes stay high on reads, and the dedicated write-enable pin stays high.
- With the policy set, the lane strobes are the lower and upper byte selects of 16-bit devices. Lanes 0/1 cover data bits 15:0 and lanes 2/3 cover bits 31:16. All four go low on reads, so no byte lane is left undriven. The write-enable pin does the writing.

A request is taken only while `ready_o` is high. A transfer wider than the bank is refused in one cycle with an error flag, and no pin moves. Every access, whether completed or refused, ends with a one-cycle `done_o` pulse.

Top module: `sram_lane_strobe`

## Requirements
- R1: While and after reset, all four lane strobes, `we_no`, `oe_no` and `cs_no` are high, `ready_o` is high, and `done_o` and `err_o` are low.
- R2: A request sampled with `req_i` and `ready_o` high starts an access. With the default phase lengths, the sequence is:
  - `cs_no` is low in the three cycles after the accepting edge (setup, strobe, hold).
  - Lane strobes, `we_no` and `oe_no` can be low only in the middle (strobe) cycle.
- R3: On a write, the lanes strobed low are set by bank width code (0 = 8-bit, 1 = 16-bit, 2 = 32-bit), size code (0 = byte, 1 = halfword, 2 = word) and the low address bits:
  - 8-bit bank: lane 0.
  - 16-bit bank: a byte uses lane addr[0]; a halfword uses lanes 1:0.
  - 32-bit bank: a byte uses lane addr[1:0]; a halfword uses lanes 3:2 if addr[1] is set, else 1:0; a word uses all four.
  - Unselected lanes stay high.
- R4: On a read with `lane_pol_i` clear, all four lane strobes stay high for the whole access.
- R5: On a read with `lane_pol_i` set, all four lane strobes are low in the strobe cycle.
- R6: `we_no` is low only in the strobe cycle of a write with `lane_pol_i` set. With the policy clear it never falls.
- R7: `oe_no` is low only in the strobe cycle of a read, never on a write.
- R8: `waddr_o` holds the byte address shifted right by 0, 1 or 2 bits for an 8-, 16- or 32-bit bank. It is valid from the setup cycle and unchanged until the access ends.
- R9: A request is refused if its size code exceeds the width code, or if either code is 3. A refused request gives one cycle with `err_o` and `done_o` high. In that cycle `cs_no` and all strobes stay high.
- R10: `done_o` pulses for one cycle in the hold cycle of a completed access. `ready_o` is low from acceptance until the access ends. A request raised while `ready_o` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Byte address |
| size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word |
| width_i | input | 2 | Bank width: 0 8-bit, 1 16-bit, 2 32-bit |
| lane_pol_i | input | 1 | Lane policy: 1 = lanes are byte selects, 0 = per-byte write enables |
| ready_o | output | 1 | Idle, able to take a request |
| done_o | output | 1 | End-of-access pulse |
| err_o | output | 1 | Refused-request pulse |
| cs_no | output | 1 | Chip select, active low |
| oe_no | output | 1 | Output enable, active low |
| we_no | output | 1 | Write enable, active low |
| lane_no | output | 4 | Byte-lane strobes, active low |
| waddr_o | output | 21 | Word address to the devices |

## Verification
Two things can fall in one cycle.
- **Busy request and running access.** A second request can arrive while an access is still running. The bench raises `req_i` with a different address during the setup and strobe cycles of a write. It judges that `waddr_o` and the lane pattern of the running access are untouched, and that `cs_no` stays high once the access ends.
- **Refusal and completion.** A refusal signals its end in the same cycle as its error. The table rows for refused requests check that `err_o` and `done_o` rise together while `cs_no` and every strobe stay high, and that `ready_o` returns in the next cycle.

// File: rtl/sram_ls_pkg.sv
package sram_ls_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2
  } bank_width_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_REJECT
  } phase_e;
endpackage

// File: rtl/sram_ls_decode.sv
module sram_ls_decode
  import sram_ls_pkg::*;
#(
  parameter int unsigned WADDR_W = 21,
  localparam int unsigned BADDR_W = WADDR_W + 2
) (
  input  logic [BADDR_W-1:0] addr_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         width_i,
  output logic [LANES-1:0]   lane_mask_o,
  output logic               reject_o,
  output logic [WADDR_W-1:0] waddr_o
);
  always_comb begin
    reject_o    = (size_i == 2'd3) || (width_i == 2'd3) || (size_i > width_i);
    lane_mask_o = '0;
    waddr_o     = addr_i[WADDR_W+1:2];
    unique case (width_i)
      BW_8: begin
        lane_mask_o = 4'b0001;
        waddr_o     = addr_i[WADDR_W-1:0];
      end
      BW_16: begin
        waddr_o = addr_i[WADDR_W:1];
        if (size_i == SZ_BYTE) lane_mask_o = addr_i[0] ? 4'b0010 : 4'b0001;
        else                   lane_mask_o = 4'b0011;
      end
      default: begin
        waddr_o = addr_i[WADDR_W+1:2];
        unique case (size_i)
          SZ_BYTE: lane_mask_o = 4'(4'b0001 << addr_i[1:0]);
          SZ_HALF: lane_mask_o = addr_i[1] ? 4'b1100 : 4'b0011;
          default: lane_mask_o = 4'b1111;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/sram_ls_fsm.sv
module sram_ls_fsm
  import sram_ls_pkg::*;
#(
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned HOLD_CYC   = 1,
  localparam int unsigned MAX_CYC =
    (SETUP_CYC > STROBE_CYC) ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                             : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC),
  localparam int unsigned CNT_W = ($clog2(MAX_CYC) < 1) ? 1 : $clog2(MAX_CYC)
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   reject_i,
  output logic   accept_o,
  output phase_e phase_d_o,
  output logic   hold_last_d_o
);
  localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    unique case (phase_q)
      PH_SETUP:  last = (cnt_q == SETUP_LAST);
      PH_STROBE: last = (cnt_q == STROBE_LAST);
      PH_HOLD:   last = (cnt_q == HOLD_LAST);
      default:   last = 1'b1;
    endcase
  end

  assign accept_o = (phase_q == PH_IDLE) && req_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = last ? '0 : cnt_q + 1'b1;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (req_i) phase_d = reject_i ? PH_REJECT : PH_SETUP;
      end
      PH_SETUP:  if (last) phase_d = PH_STROBE;
      PH_STROBE: if (last) phase_d = PH_HOLD;
      PH_HOLD:   if (last) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  assign phase_d_o     = phase_d;
  assign hold_last_d_o = (phase_d == PH_HOLD) && (cnt_d == HOLD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_ls_pins.sv
module sram_ls_pins
  import sram_ls_pkg::*;
#(
  parameter int unsigned WADDR_W = 21
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             phase_d_i,
  input  logic               hold_last_d_i,
  input  logic               accept_i,
  input  logic               wr_i,
  input  logic               pol_i,
  input  logic [LANES-1:0]   mask_i,
  input  logic [WADDR_W-1:0] waddr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               err_o,
  output logic               cs_no,
  output logic               oe_no,
  output logic               we_no,
  output logic [LANES-1:0]   lane_no,
  output logic [WADDR_W-1:0] waddr_o
);
  logic             wr_q, pol_q;
  logic [LANES-1:0] mask_q;
  logic             cur_wr, cur_pol;
  logic [LANES-1:0] cur_mask;
  logic             strobe_d, active_d;

  // new request steers the first registered phase directly
  assign cur_wr   = accept_i ? wr_i   : wr_q;
  assign cur_pol  = accept_i ? pol_i  : pol_q;
  assign cur_mask = accept_i ? mask_i : mask_q;
  assign strobe_d = (phase_d_i == PH_STROBE);
  assign active_d = (phase_d_i == PH_SETUP) || strobe_d || (phase_d_i == PH_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      pol_q   <= 1'b0;
      mask_q  <= '0;
      waddr_o <= '0;
    end else if (accept_i) begin
      wr_q    <= wr_i;
      pol_q   <= pol_i;
      mask_q  <= mask_i;
      waddr_o <= waddr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b1;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      cs_no   <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
    end else begin
      ready_o <= (phase_d_i == PH_IDLE);
      done_o  <= hold_last_d_i || (phase_d_i == PH_REJECT);
      err_o   <= (phase_d_i == PH_REJECT);
      cs_no   <= ~active_d;
      oe_no   <= ~(strobe_d && !cur_wr);
      we_no   <= ~(strobe_d && cur_wr && cur_pol);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_no[g] <= 1'b1;
      else         lane_no[g] <= ~(strobe_d && (cur_wr ? cur_mask[g] : cur_pol));
    end
  end
endmodule

// File: rtl/sram_lane_strobe.sv
module sram_lane_strobe
  import sram_ls_pkg::*;
#(
  parameter int unsigned WADDR_W    = 21,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 1,
  parameter int unsigned HOLD_CYC   = 1,
  localparam int unsigned BADDR_W   = WADDR_W + 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic [BADDR_W-1:0] addr_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         width_i,
  input  logic               lane_pol_i,
  output logic               ready_o,
  output logic               done_o,
  output logic               err_o,
  output logic               cs_no,
  output logic               oe_no,
  output logic               we_no,
  output logic [LANES-1:0]   lane_no,
  output logic [WADDR_W-1:0] waddr_o
);
  logic [LANES-1:0]   dec_mask;
  logic               dec_reject;
  logic [WADDR_W-1:0] dec_waddr;
  logic               accept;
  phase_e             phase_d;
  logic               hold_last_d;

  sram_ls_decode #(.WADDR_W(WADDR_W)) u_decode (
    .addr_i     (addr_i),
    .size_i     (size_i),
    .width_i    (width_i),
    .lane_mask_o(dec_mask),
    .reject_o   (dec_reject),
    .waddr_o    (dec_waddr)
  );

  sram_ls_fsm #(
    .SETUP_CYC (SETUP_CYC),
    .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .reject_i     (dec_reject),
    .accept_o     (accept),
    .phase_d_o    (phase_d),
    .hold_last_d_o(hold_last_d)
  );

  sram_ls_pins #(.WADDR_W(WADDR_W)) u_pins (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .phase_d_i    (phase_d),
    .hold_last_d_i(hold_last_d),
    .accept_i     (accept),
    .wr_i         (wr_i),
    .pol_i        (lane_pol_i),
    .mask_i       (dec_mask),
    .waddr_i      (dec_waddr),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .cs_no        (cs_no),
    .oe_no        (oe_no),
    .we_no        (we_no),
    .lane_no      (lane_no),
    .waddr_o      (waddr_o)
  );
endmodule

// File: rtl/sram_lane_strobe_chk.sv
module sram_lane_strobe_chk #(
  parameter int unsigned WADDR_W = 21,
  localparam int unsigned BADDR_W = WADDR_W + 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               wr_i,
  input logic [BADDR_W-1:0] addr_i,
  input logic [1:0]         size_i,
  input logic [1:0]         width_i,
  input logic               lane_pol_i,
  input logic               ready_o,
  input logic               done_o,
  input logic               err_o,
  input logic               cs_no,
  input logic               oe_no,
  input logic               we_no,
  input logic [3:0]         lane_no,
  input logic [WADDR_W-1:0] waddr_o
);
  // R2
  lanes_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_no != 4'hF) |-> !cs_no);
  // R6
  we_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !cs_no);
  // R7
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no));
  // R8
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $past(!cs_no)) |-> $stable(waddr_o));
  // R9
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && we_no && oe_no && lane_no == 4'hF && done_o));
  // R10
  done_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
  // R10
  accept_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i) |=> (!cs_no || err_o));
endmodule

bind sram_lane_strobe sram_lane_strobe_chk #(.WADDR_W(WADDR_W)) u_chk (.*);

// File: tb/sram_lane_strobe_tb.sv
`timescale 1ns/1ps
module sram_lane_strobe_tb;
  typedef struct packed {
    logic       wr;
    logic [1:0] sz;
    logic [1:0] wd;
    logic       pol;
    logic [1:0] a;
    logic [3:0] lanes;
    logic       we;
    logic       oe;
    logic       err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 2'd2, 1'b0, 2'd2, 4'b1011, 1'b1, 1'b1, 1'b0}, // R3 byte w32 lane2
    '{1'b1, 2'd0, 2'd2, 1'b0, 2'd1, 4'b1101, 1'b1, 1'b1, 1'b0}, // R3 byte w32 lane1
    '{1'b1, 2'd1, 2'd2, 1'b0, 2'd2, 4'b0011, 1'b1, 1'b1, 1'b0}, // R3 half upper
    '{1'b1, 2'd1, 2'd2, 1'b1, 2'd0, 4'b1100, 1'b0, 1'b1, 1'b0}, // R6 half lower pol
    '{1'b1, 2'd2, 2'd2, 1'b0, 2'd3, 4'b0000, 1'b1, 1'b1, 1'b0}, // R3 word
    '{1'b1, 2'd2, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b0, 1'b1, 1'b0}, // R6 word pol
    '{1'b0, 2'd2, 2'd2, 1'b0, 2'd0, 4'b1111, 1'b1, 1'b0, 1'b0}, // R4 read
    '{1'b0, 2'd2, 2'd2, 1'b1, 2'd0, 4'b0000, 1'b1, 1'b0, 1'b0}, // R5 read pol
    '{1'b0, 2'd1, 2'd1, 1'b1, 2'd2, 4'b0000, 1'b1, 1'b0, 1'b0}, // R5 read w16
    '{1'b1, 2'd0, 2'd1, 1'b1, 2'd1, 4'b1101, 1'b0, 1'b1, 1'b0}, // R3 byte w16
    '{1'b1, 2'd1, 2'd1, 1'b0, 2'd3, 4'b1100, 1'b1, 1'b1, 1'b0}, // R3 half w16
    '{1'b1, 2'd0, 2'd0, 1'b0, 2'd3, 4'b1110, 1'b1, 1'b1, 1'b0}, // R3 byte w8
    '{1'b1, 2'd1, 2'd0, 1'b0, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1}, // R9 half on w8
    '{1'b0, 2'd2, 2'd1, 1'b1, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1}, // R9 word on w16
    '{1'b1, 2'd0, 2'd3, 1'b0, 2'd0, 4'b1111, 1'b1, 1'b1, 1'b1}  // R9 width code 3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [22:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [1:0]  width_i = '0;
  logic        lane_pol_i = 1'b0;
  logic        ready_o, done_o, err_o, cs_no, oe_no, we_no;
  logic [3:0]  lane_no;
  logic [20:0] waddr_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  sram_lane_strobe u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .size_i(size_i), .width_i(width_i), .lane_pol_i(lane_pol_i),
    .ready_o(ready_o), .done_o(done_o), .err_o(err_o), .cs_no(cs_no),
    .oe_no(oe_no), .we_no(we_no), .lane_no(lane_no), .waddr_o(waddr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] exp_waddr(input logic [22:0] a, input logic [1:0] wd);
    case (wd)
      2'd0:    return a[20:0];
      2'd1:    return a[21:1];
      default: return a[22:2];
    endcase
  endfunction

  // control pins packed as {cs,oe,we,lanes}
  function automatic logic [31:0] pins();
    return {25'd0, cs_no, oe_no, we_no, lane_no};
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    logic [22:0] a;
    a = {21'(21'h0B5C3 + idx * 37), v.a};
    @(negedge clk_i);
    req_i = 1'b1; wr_i = v.wr; size_i = v.sz; width_i = v.wd;
    lane_pol_i = v.pol; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    if (v.err) begin
      check("R9 reject pins", pins(), {25'd0, 7'h7F});
      check("R9 err/done", {30'd0, err_o, done_o}, 32'd3);
      @(negedge clk_i);
      check("R9 ready back", {31'd0, ready_o}, 32'd1);
    end else begin
      check("R2 setup pins", pins(), {25'd0, 3'b011, 4'hF});
      check("R10 busy", {31'd0, ready_o}, 32'd0);
      check("R8 waddr", {11'd0, waddr_o}, {11'd0, exp_waddr(a, v.wd)});
      @(negedge clk_i);
      check("R3 R4 R5 R6 R7 strobe", pins(), {25'd0, 1'b0, v.oe, v.we, v.lanes});
      @(negedge clk_i);
      check("R2 hold pins", pins(), {25'd0, 3'b011, 4'hF});
      check("R10 done", {31'd0, done_o}, 32'd1);
      check("R8 waddr hold", {11'd0, waddr_o}, {11'd0, exp_waddr(a, v.wd)});
      @(negedge clk_i);
      check("R2 idle pins", pins(), {25'd0, 7'h7F});
      check("R10 idle", {30'd0, ready_o, done_o}, 32'd2);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [22:0] a0;
    #12;
    // R1
    check("R1 reset pins", pins(), {25'd0, 7'h7F});
    check("R1 reset flags", {29'd0, ready_o, done_o, err_o}, 32'd4);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset", {28'd0, ready_o, done_o, err_o, cs_no}, 32'b1001);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10 request while busy is ignored
    a0 = 23'h2A5556;
    @(negedge clk_i);
    req_i = 1'b1; wr_i = 1'b1; size_i = 2'd0; width_i = 2'd2;
    lane_pol_i = 1'b0; addr_i = a0;
    @(negedge clk_i);
    addr_i = 23'h11111; size_i = 2'd2; wr_i = 1'b0;
    @(negedge clk_i);
    check("R10 busy strobe lanes", pins(), {25'd0, 3'b011, 4'b1011});
    check("R10 busy waddr", {11'd0, waddr_o}, {11'd0, a0[22:2]});
    req_i = 1'b0;
    @(negedge clk_i);
    check("R10 busy hold waddr", {11'd0, waddr_o}, {11'd0, a0[22:2]});
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 no second access", {30'd0, cs_no, ready_o}, 32'd3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule